// File: doc/BRIEF.md
# Accumulator-Based Test Pattern Generator

This block is a built-in self-test stimulus source built from an adder and an accumulator. A small external table holds entries of two fields, a seed and a run length. For each entry the block first shows the seed as a pattern. After that it adds an increment on every cycle and emits one W-bit pattern per cycle until the entry's run length is used up. The increment is the same seed with its least significant bit forced high.

Because the increment is always odd, a run of length 2^W visits every W-bit value exactly once. The table therefore needs no separate increment field. Entries are read in index order through a registered read port that returns data one cycle after the request. The next entry is prefetched while the current run is still being emitted, so back-to-back runs leave no gap.

A start pulse begins a session at entry 0. When the last entry is finished, a done level is raised and the pattern-valid flag stays low. For every entry the block also measures the longest run of equal bits in the increment. When that run exceeds RUN_MAX, a side flag is raised for as long as the entry's patterns are shown, because such an increment leaves some pattern bits without toggling. Generation continues in that case.

Top module: `addgen_bist`

## Requirements
- R1: The first pattern of each entry's run equals that entry's seed, before any addition.
- R2: Every later pattern of a run equals the previous pattern plus (seed with bit 0 forced to 1), modulo 2^W.
- R3: Because bit 0 of the increment is forced to 1, an entry of length 2^W emits all 2^W distinct values, whether its seed is odd or even.
- R4: Entries are applied in ascending index order 0 to K-1, and entry i emits exactly its length value of patterns.
- R5: An entry whose length field is 0 emits no pattern and is skipped.
- R6: After reset the block is idle, with done_o, pat_vld_o and tbl_rd_o all 0. After the last entry, done_o is held at 1 with pat_vld_o at 0 until the next start pulse.
- R7: A start pulse that arrives while a session is running has no effect on the emitted sequence.
- R8: A table read shows tbl_rd_o=1 with an address below K, and the data is sampled on the following cycle. At most one read is in flight at any time.
- R9: When every entry of a session has a length of at least 2, pat_vld_o stays high without a gap from the first pattern to the last.
- R10: The flag run_flag_o is 1 exactly on the valid cycles of an entry whose increment (seed with bit 0 forced to 1) has a run of more than RUN_MAX equal adjacent bits, counting 1-runs and 0-runs alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a session at entry 0 |
| done_o | output | 1 | High after the last entry until the next start |
| tbl_rd_o | output | 1 | Table read request |
| tbl_addr_o | output | IDX_W | Table entry index |
| tbl_seed_i | input | W | Seed field, valid one cycle after the request |
| tbl_len_i | input | LEN_W | Run-length field, valid one cycle after the request |
| pat_o | output | W | Current test pattern |
| pat_vld_o | output | 1 | Pattern valid |
| run_flag_o | output | 1 | Current increment has an over-long run of equal bits |

## Verification
The bench goes after the following corner cases.
- **Full period with every odd increment, and with even seeds.** The bench runs sessions that cover every odd increment of a 5-bit generator, and a session with even seeds. A design that did not force bit 0 would revisit values early and miss part of the value set.
- **Zero-length and length-1 entries.** These are mixed into a session. A design that mishandled them would emit a stray seed pattern or would drop or repeat an entry.
- **Gapless sessions.** A session whose entries all have a length of at least 2 is checked for gaps. A prefetch that failed to hide the read latency would leave one idle cycle between runs.
- **Run flag and restart.** Increments with long 1-runs and long 0-runs above bit 0 are compared against an independent run-length count. A start pulse is also sent in the middle of a session, where a design that restarted would repeat entry 0.

// File: rtl/addgen_pkg.sv
// Shared types for the accumulator-based pattern generator.
// Assumes: nothing beyond IEEE 1800-2017.
package addgen_pkg;
    typedef enum logic [1:0] {
        SESS_IDLE = 2'd0,
        SESS_BUSY = 2'd1,
        SESS_DONE = 2'd2
    } sess_e;
endpackage

// File: rtl/addgen_runchk.sv
// Longest-run detector: flags an increment whose longest stretch of equal
// adjacent bits (ones or zeros) is longer than RUN_MAX.
// Assumes: W >= 2; purely combinational.
module addgen_runchk #(
    parameter int W       = 8,
    parameter int RUN_MAX = 4
) (
    input  logic [W-1:0] inc_i,
    output logic         long_o
);
    int run_len;
    int best_len;

    // Purpose: scan the increment once, tracking current and longest run.
    always_comb begin
        run_len  = 1;
        best_len = 1;
        for (int b = 1; b < W; b++) begin
            if (inc_i[b] == inc_i[b-1]) begin
                run_len = run_len + 1;
            end else begin
                run_len = 1;
            end
            if (run_len > best_len) begin
                best_len = run_len;
            end
        end
        long_o = (best_len > RUN_MAX);
    end
endmodule

// File: rtl/addgen_fetch.sv
// Entry prefetcher: walks the table in index order through a read port with
// one cycle of latency and keeps one ready entry in a slot register. Entries
// with a zero length are dropped on arrival.
// Assumes: K >= 2; at most one read in flight; the slot is free when data lands.
module addgen_fetch #(
    parameter int W     = 8,
    parameter int K     = 4,
    parameter int LEN_W = 8,
    localparam int IDX_W = $clog2(K),
    localparam int PTR_W = $clog2(K + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             active_i,
    input  logic             take_i,
    output logic             rd_o,
    output logic [IDX_W-1:0] addr_o,
    input  logic [W-1:0]     seed_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             slot_vld_o,
    output logic [W-1:0]     slot_seed_o,
    output logic [LEN_W-1:0] slot_len_o,
    output logic             drained_o
);
    logic [PTR_W-1:0] ptr_q;
    logic             pend_q;
    logic             slot_vld_q;
    logic [W-1:0]     slot_seed_q;
    logic [LEN_W-1:0] slot_len_q;

    // Purpose: issue a read only when the slot will be free and none is pending.
    always_comb begin
        rd_o = active_i && (!slot_vld_q || take_i) && !pend_q
               && (ptr_q < PTR_W'(K));
    end

    assign addr_o      = ptr_q[IDX_W-1:0];
    assign slot_vld_o  = slot_vld_q;
    assign slot_seed_o = slot_seed_q;
    assign slot_len_o  = slot_len_q;
    assign drained_o   = (ptr_q == PTR_W'(K)) && !pend_q && !slot_vld_q;

    // Purpose: advance the read pointer and fill or empty the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            pend_q      <= 1'b0;
            slot_vld_q  <= 1'b0;
            slot_seed_q <= '0;
            slot_len_q  <= '0;
        end else if (begin_i) begin
            ptr_q      <= '0;
            pend_q     <= 1'b0;
            slot_vld_q <= 1'b0;
        end else begin
            pend_q <= rd_o;
            if (rd_o) begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
            if (pend_q && (len_i != '0)) begin
                slot_vld_q  <= 1'b1;
                slot_seed_q <= seed_i;
                slot_len_q  <= len_i;
            end else if (take_i) begin
                slot_vld_q <= 1'b0;
            end
        end
    end

    // R8: a request is never followed directly by another one.
    a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o);
    // R5: an empty entry never reaches the slot.
    a_r5_no_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_o |-> (slot_len_o != '0));
endmodule

// File: rtl/addgen_accum.sv
// Adder and accumulator: shows the seed, then adds the odd increment
// (seed with bit 0 forced high) once per cycle for the loaded length.
// Assumes: load_i only with a nonzero length.
module addgen_accum #(
    parameter int W       = 8,
    parameter int LEN_W   = 8,
    parameter int RUN_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [W-1:0]     seed_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [W-1:0]     pat_o,
    output logic             flag_o
);
    logic [W-1:0]     acc_q;
    logic [W-1:0]     inc_q;
    logic [LEN_W-1:0] cnt_q;
    logic             busy_q;
    logic             flag_q;
    logic [W-1:0]     odd_inc;
    logic             long_run;

    assign odd_inc = {seed_i[W-1:1], 1'b1};

    addgen_runchk #(.W(W), .RUN_MAX(RUN_MAX)) runchk_i (
        .inc_i  (odd_inc),
        .long_o (long_run)
    );

    assign busy_o = busy_q;
    assign last_o = busy_q && (cnt_q == LEN_W'(1));
    assign pat_o  = acc_q;
    assign flag_o = busy_q && flag_q;

    // Purpose: load a new entry or step the accumulator and the length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            inc_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (clear_i) begin
            busy_q <= 1'b0;
        end else if (load_i) begin
            acc_q  <= seed_i;
            inc_q  <= odd_inc;
            cnt_q  <= len_i;
            busy_q <= 1'b1;
            flag_q <= long_run;
        end else if (busy_q) begin
            acc_q <= acc_q + inc_q;
            cnt_q <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    // R3: the increment in use is always odd.
    a_r3_odd_increment: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> inc_q[0]);
    // R4: a running entry never has an exhausted counter.
    a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q != '0));
    // R2: inside a run, the next pattern is the previous plus the increment.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (busy_o && (pat_o == $past(pat_o) + $past(inc_q))));
    // R1: a load shows the seed next.
    a_r1_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (pat_o == $past(seed_i)));
endmodule

// File: rtl/addgen_bist.sv
// Top of the accumulator-based test pattern generator: session control
// around the entry prefetcher and the adder/accumulator.
// Assumes: table read data is valid one cycle after tbl_rd_o; K >= 2.
module addgen_bist
    import addgen_pkg::*;
#(
    parameter int W       = 8,
    parameter int K       = 4,
    parameter int LEN_W   = 8,
    parameter int RUN_MAX = 4,
    localparam int IDX_W  = $clog2(K)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             done_o,
    output logic             tbl_rd_o,
    output logic [IDX_W-1:0] tbl_addr_o,
    input  logic [W-1:0]     tbl_seed_i,
    input  logic [LEN_W-1:0] tbl_len_i,
    output logic [W-1:0]     pat_o,
    output logic             pat_vld_o,
    output logic             run_flag_o
);
    sess_e            sess_q;
    logic             begin_s;
    logic             active_s;
    logic             take_s;
    logic             slot_vld;
    logic [W-1:0]     slot_seed;
    logic [LEN_W-1:0] slot_len;
    logic             drained;
    logic             gen_busy;
    logic             gen_last;

    assign begin_s  = start_i && (sess_q != SESS_BUSY);
    assign active_s = (sess_q == SESS_BUSY);
    assign take_s   = active_s && slot_vld && (!gen_busy || gen_last);
    assign done_o   = (sess_q == SESS_DONE);
    assign pat_vld_o = gen_busy;

    addgen_fetch #(.W(W), .K(K), .LEN_W(LEN_W)) fetch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .begin_i     (begin_s),
        .active_i    (active_s),
        .take_i      (take_s),
        .rd_o        (tbl_rd_o),
        .addr_o      (tbl_addr_o),
        .seed_i      (tbl_seed_i),
        .len_i       (tbl_len_i),
        .slot_vld_o  (slot_vld),
        .slot_seed_o (slot_seed),
        .slot_len_o  (slot_len),
        .drained_o   (drained)
    );

    addgen_accum #(.W(W), .LEN_W(LEN_W), .RUN_MAX(RUN_MAX)) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (begin_s),
        .load_i  (take_s),
        .seed_i  (slot_seed),
        .len_i   (slot_len),
        .busy_o  (gen_busy),
        .last_o  (gen_last),
        .pat_o   (pat_o),
        .flag_o  (run_flag_o)
    );

    // Purpose: session state: idle, running, finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sess_q <= SESS_IDLE;
        end else if (begin_s) begin
            sess_q <= SESS_BUSY;
        end else if (active_s && drained && !gen_busy) begin
            sess_q <= SESS_DONE;
        end
    end

    // R6: a finished session shows no patterns.
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pat_vld_o);
    // R8: requests address only existing entries.
    a_r8_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_o |-> (int'(tbl_addr_o) < K));
    // R7: a start during a running session keeps it running.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active_s && start_i && !drained) |=> !done_o);
endmodule

// File: tb/addgen_bist_tb_top.sv
// Self-checking bench: behavioural queue model of the expected patterns.
module addgen_bist_tb_top;
    localparam int W       = 5;
    localparam int K       = 8;
    localparam int LEN_W   = 7;
    localparam int RUN_MAX = 2;
    localparam int IDX_W   = $clog2(K);
    localparam int NVAL    = 1 << W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             done;
    logic             tbl_rd;
    logic [IDX_W-1:0] tbl_addr;
    logic [W-1:0]     rd_seed = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic [W-1:0]     pat;
    logic             pat_vld;
    logic             run_flag;

    logic [W-1:0]     tseed [K];
    logic [LEN_W-1:0] tlen  [K];

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [W-1:0] exp_p [$];
    bit           exp_f [$];
    int           exp_e [$];
    bit           exp_first [$];
    bit           seen [K][NVAL];
    bit           started = 0;
    int           gaps = 0;
    bit           prev_rd = 0;

    always #10 clk = ~clk;

    addgen_bist #(.W(W), .K(K), .LEN_W(LEN_W), .RUN_MAX(RUN_MAX)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .done_o     (done),
        .tbl_rd_o   (tbl_rd),
        .tbl_addr_o (tbl_addr),
        .tbl_seed_i (rd_seed),
        .tbl_len_i  (rd_len),
        .pat_o      (pat),
        .pat_vld_o  (pat_vld),
        .run_flag_o (run_flag)
    );

    // Table memory with one cycle of read latency.
    always @(posedge clk) begin
        if (tbl_rd) begin
            rd_seed <= tseed[tbl_addr];
            rd_len  <= tlen[tbl_addr];
        end
    end

    function automatic bit long_run(input logic [W-1:0] v);
        int run = 1;
        int best = 1;
        for (int b = 1; b < W; b++) begin
            run = (v[b] == v[b-1]) ? run + 1 : 1;
            if (run > best) best = run;
        end
        return best > RUN_MAX;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Cycle monitor: compare every valid pattern against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(tbl_rd && prev_rd), "R8", "back-to-back reads", 1, 0);
            prev_rd = tbl_rd;
            if (pat_vld) begin
                started = 1;
                if (exp_p.size() == 0) begin
                    check(0, "R4", "extra pattern", int'(pat), -1);
                end else begin
                    logic [W-1:0] ep;
                    bit ef;
                    int ee;
                    bit fst;
                    ep = exp_p.pop_front();
                    ef = exp_f.pop_front();
                    ee = exp_e.pop_front();
                    fst = exp_first.pop_front();
                    if (fst) check(pat == ep, "R1", "seed pattern", int'(pat), int'(ep));
                    else     check(pat == ep, "R2", "stepped pattern", int'(pat), int'(ep));
                    check(run_flag == ef, "R10", "run flag", int'(run_flag), int'(ef));
                    seen[ee][pat] = 1;
                end
            end else begin
                check(!run_flag, "R10", "flag outside valid", int'(run_flag), 0);
                if (started && exp_p.size() != 0) gaps++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic run_session(input bit gapless, input bit mid_start);
        for (int i = 0; i < K; i++) begin
            logic [W-1:0] p = tseed[i];
            for (int v = 0; v < NVAL; v++) seen[i][v] = 0;
            for (int n = 0; n < int'(tlen[i]); n++) begin
                exp_p.push_back(p);
                exp_f.push_back(long_run({tseed[i][W-1:1], 1'b1}));
                exp_e.push_back(i);
                exp_first.push_back(n == 0);
                p = p + {tseed[i][W-1:1], 1'b1};
            end
        end
        started = 0;
        gaps = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (mid_start) begin
            repeat (6) @(negedge clk);
            start = 1;
            @(negedge clk) start = 0;
        end
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done) break;
        end
        check(exp_p.size() == 0, "R4", "patterns left", exp_p.size(), 0);
        check(done == 1'b1, "R6", "done after last entry", int'(done), 1);
        check(pat_vld == 1'b0, "R6", "valid low when done", int'(pat_vld), 0);
        if (gapless) check(gaps == 0, "R9", "gap cycles", gaps, 0);
        repeat (4) @(negedge clk);
        check(done == 1'b1 && !pat_vld, "R6", "done held", int'(done), 1);
        exp_p.delete(); exp_f.delete(); exp_e.delete(); exp_first.delete();
    endtask

    task automatic check_full_period();
        for (int i = 0; i < K; i++) begin
            int cnt = 0;
            for (int v = 0; v < NVAL; v++) cnt += int'(seen[i][v]);
            check(cnt == NVAL, "R3", "distinct values in full run", cnt, NVAL);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !pat_vld && !tbl_rd, "R6", "reset idle",
              int'({done, pat_vld, tbl_rd}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !pat_vld, "R6", "idle before start", int'({done, pat_vld}), 0);

        // Mixed session with zero-length (R5) and length-1 entries, long-run seeds.
        tseed[0] = 5'h0A; tlen[0] = 3;
        tseed[1] = 5'h13; tlen[1] = 0;
        tseed[2] = 5'h07; tlen[2] = 4;
        tseed[3] = 5'h01; tlen[3] = 1;
        tseed[4] = 5'h1F; tlen[4] = 2;
        tseed[5] = 5'h06; tlen[5] = 5;
        tseed[6] = 5'h00; tlen[6] = 0;
        tseed[7] = 5'h1B; tlen[7] = 3;
        run_session(0, 0);
        check(seen[1][5'h13] == 0 && seen[6][0] == 0, "R5", "skipped entries silent",
              int'(seen[1][5'h13]), 0);

        // Gapless session with a start pulse in the middle (R7, R9).
        for (int i = 0; i < K; i++) begin
            tseed[i] = 5'(3 * i + 4);
            tlen[i]  = 7'(2 + (i % 4));
        end
        run_session(1, 1);

        // Full period over every odd increment, then with even seeds (R3).
        for (int grp = 0; grp < 3; grp++) begin
            for (int i = 0; i < K; i++) begin
                if (grp < 2) tseed[i] = 5'(2 * (i + grp * K) + 1);
                else         tseed[i] = 5'(2 * i);
                tlen[i] = 7'(NVAL);
            end
            run_session(1, 0);
            check_full_period();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule